// File: doc/BRIEF.md
# 4B/5B PCS receive deframer

This block sits behind code-group alignment on a 100 Mb/s receive path. It accepts one 5-bit code-group per transfer and turns the symbol stream into a nibble stream toward the MAC. While the line is idle it waits for a start delimiter. That delimiter is a /J/ code-group followed at once by /K/. In place of that pair it sends two preamble nibbles. It then decodes data code-groups to nibbles until the frame ends, either with the /T/R/ end delimiter or with a premature return to IDLE.

Every decoded nibble waits in a one-entry hold stage until the next code-group arrives. At the end of a frame the block therefore still owns the final nibble. A 3-bit dribble count comes with the end code-group, and from it the block decides whether that final nibble is passed on or dropped. Bad code-groups inside a frame become error-flagged nibbles. A frame cut short by IDLE is reported on a one-cycle status pulse.

Both data sides use valid/ready. A code-group transfers when `in_valid` and `in_ready` are high at a rising edge, and a nibble transfers when `out_valid` and `out_ready` are high. The output register holds one nibble. `in_ready` is high when that register is empty or is being drained in the same cycle, so a stalled sink stops the symbol stream without losing or repeating anything. While `out_valid` is high and `out_ready` is low, the data and error bits stay unchanged.

Top module: `pcs_rx_deframer`

## Requirements
- R1: During and right after a synchronous active-high reset, `out_valid` and `early_end` are 0 and `in_ready` is 1.
- R2: The sixteen data code-groups decode, written MSB first, as follows: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. Inside a frame each one yields its nibble with `out_err`=0, and nibbles leave in arrival order.
- R3: The control code-groups are IDLE=11111, J=11000, K=10001, T=01101 and R=00111. A J that follows an IDLE and is directly followed by a K yields two nibbles of value 0x5 with `out_err`=0, ahead of the frame data.
- R4: A J is honoured only straight after an IDLE. A J followed by anything other than K produces no output nibble. After such a J, or after any other code-group outside a frame, a J is ignored until an IDLE has been received.
- R5: A T inside a frame ends it. Neither T nor the R after it is forwarded. If the dribble count given with the T is 0 to 4, every frame nibble is delivered.
- R6: If the dribble count given with the ending code-group is 5 to 7, the last nibble of the frame is dropped. This nibble is the second preamble nibble when the frame had no data.
- R7: Inside a frame, a code-group that is neither a data code-group, T nor IDLE yields a nibble of value 0 with `out_err`=1.
- R8: An IDLE inside a frame ends it with the same dribble rule as T. `early_end` is high for exactly the one cycle after that IDLE is accepted, and at no other time.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_err` stay unchanged into the next cycle.
- R10: The first preamble nibble is presented in the cycle after K is accepted. Each later nibble is presented in the cycle after the code-group following it (data, error, T or IDLE) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A code-group is offered |
| in_ready | output | 1 | The block can take a code-group this cycle |
| in_code | input | 5 | Code-group, MSB first as written in R2/R3 |
| in_dribble | input | 3 | Bits beyond the last whole octet, used with the ending T or IDLE |
| out_valid | output | 1 | A nibble is offered to the MAC |
| out_ready | input | 1 | The MAC takes the nibble this cycle |
| out_data | output | 4 | Receive nibble |
| out_err | output | 1 | Receive error for this nibble |
| early_end | output | 1 | One-cycle pulse: frame ended by IDLE without T/R |

## Verification
All results come from registers. The first preamble nibble is due in the cycle after K is accepted. Every later nibble is due in the cycle after the next code-group is accepted, and the final nibble follows the accepted T or IDLE by one cycle. `early_end` is due one cycle after the premature IDLE is accepted. The bench drives inputs on the falling edge. It samples one nanosecond later, before the next rising edge, and records which transfers that edge will complete. It compares nibbles only when a transfer actually takes place, against a queue built ahead of each frame from the requirements. The `early_end` check is armed for the sample after the accepting edge.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;

  localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R    = 5'b00111;

  typedef enum logic [2:0] {
    SK_DATA, SK_IDLE, SK_J, SK_K, SK_T, SK_R, SK_BAD
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_SEEK, ST_ARMED, ST_GOT_J, ST_FRAME, ST_GOT_T
  } rx_state_e;

  typedef struct packed {
    logic             err;
    logic [NIB_W-1:0] nib;
  } rx_beat_t;

  localparam int BEAT_W = $bits(rx_beat_t);
endpackage

// File: rtl/pcs_rx_decode.sv
module pcs_rx_decode
  import pcs_rx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output sym_kind_e         kind,
  output logic [NIB_W-1:0]  nib
);
  always_comb begin
    kind = SK_DATA;
    nib  = '0;
    case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      CG_IDLE:  kind = SK_IDLE;
      CG_J:     kind = SK_J;
      CG_K:     kind = SK_K;
      CG_T:     kind = SK_T;
      CG_R:     kind = SK_R;
      default:  kind = SK_BAD;
    endcase
  end
endmodule

// File: rtl/pcs_rx_ctrl.sv
module pcs_rx_ctrl
  import pcs_rx_pkg::*;
#(
  parameter int               DRIB_W   = 3,
  parameter int               DROP_MIN = 5,
  parameter logic [NIB_W-1:0] PRE_NIB  = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  sym_kind_e         kind,
  input  logic [NIB_W-1:0]  nib,
  input  logic [DRIB_W-1:0] dribble,
  output logic              emit,
  output rx_beat_t          emit_beat,
  output logic              early_end
);
  rx_state_e state_q, state_d;
  rx_beat_t  hold_q, hold_d;
  logic      early_d;
  logic      keep_tail;

  assign keep_tail = (int'(dribble) < DROP_MIN);

  always_comb begin
    state_d   = state_q;
    hold_d    = hold_q;
    emit      = 1'b0;
    emit_beat = hold_q;
    early_d   = 1'b0;
    if (fire) begin
      case (state_q)
        ST_SEEK: begin
          if (kind == SK_IDLE) state_d = ST_ARMED;
        end
        ST_ARMED: begin
          if (kind == SK_J)         state_d = ST_GOT_J;
          else if (kind != SK_IDLE) state_d = ST_SEEK;
        end
        ST_GOT_J: begin
          if (kind == SK_K) begin
            state_d   = ST_FRAME;
            emit      = 1'b1;
            emit_beat = '{err: 1'b0, nib: PRE_NIB};
            hold_d    = '{err: 1'b0, nib: PRE_NIB};
          end else if (kind == SK_IDLE) begin
            state_d = ST_ARMED;
          end else begin
            state_d = ST_SEEK;
          end
        end
        ST_FRAME: begin
          case (kind)
            SK_DATA: begin
              emit   = 1'b1;
              hold_d = '{err: 1'b0, nib: nib};
            end
            SK_T: begin
              emit    = keep_tail;
              state_d = ST_GOT_T;
            end
            SK_IDLE: begin
              emit    = keep_tail;
              early_d = 1'b1;
              state_d = ST_ARMED;
            end
            default: begin
              emit   = 1'b1;
              hold_d = '{err: 1'b1, nib: '0};
            end
          endcase
        end
        ST_GOT_T: begin
          if (kind == SK_IDLE) state_d = ST_ARMED;
          else                 state_d = ST_SEEK;
        end
        default: state_d = ST_SEEK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_SEEK;
      hold_q    <= '0;
      early_end <= 1'b0;
    end else begin
      state_q   <= state_d;
      hold_q    <= hold_d;
      early_end <= early_d;
    end
  end
endmodule

// File: rtl/pcs_rx_outreg.sv
module pcs_rx_outreg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         take_ok
);
  assign take_ok = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcs_rx_deframer.sv
module pcs_rx_deframer
  import pcs_rx_pkg::*;
#(
  parameter int               DRIB_W   = 3,
  parameter int               DROP_MIN = 5,
  parameter logic [NIB_W-1:0] PRE_NIB  = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [DRIB_W-1:0] in_dribble,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NIB_W-1:0]  out_data,
  output logic              out_err,
  output logic              early_end
);
  sym_kind_e        kind;
  logic [NIB_W-1:0] dec_nib;
  logic             fire;
  logic             emit;
  rx_beat_t         emit_beat;
  rx_beat_t         out_beat;

  assign fire = in_valid && in_ready;

  pcs_rx_decode u_dec (
    .code (in_code),
    .kind (kind),
    .nib  (dec_nib)
  );

  pcs_rx_ctrl #(
    .DRIB_W   (DRIB_W),
    .DROP_MIN (DROP_MIN),
    .PRE_NIB  (PRE_NIB)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .kind      (kind),
    .nib       (dec_nib),
    .dribble   (in_dribble),
    .emit      (emit),
    .emit_beat (emit_beat),
    .early_end (early_end)
  );

  pcs_rx_outreg #(
    .W (BEAT_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (emit),
    .din       (emit_beat),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .dout      (out_beat),
    .take_ok   (in_ready)
  );

  assign out_data = out_beat.nib;
  assign out_err  = out_beat.err;
endmodule

// File: rtl/pcs_rx_deframer_chk.sv
module pcs_rx_deframer_chk
  import pcs_rx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NIB_W-1:0]  out_data,
  input logic              out_err,
  input logic              early_end
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  // R9
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  // R8
  early_source_chk: assert property (@(posedge clk) disable iff (rst)
    early_end |-> $past(in_valid && in_ready && (in_code == CG_IDLE)));

  // R10
  beat_needs_symbol_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R7
  err_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_data == '0));
endmodule

bind pcs_rx_deframer pcs_rx_deframer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err),
  .early_end (early_end)
);

// File: tb/tb_pcs_rx_deframer.sv
module tb_pcs_rx_deframer;
  localparam logic [4:0] C_IDLE = 5'b11111;
  localparam logic [4:0] C_J    = 5'b11000;
  localparam logic [4:0] C_K    = 5'b10001;
  localparam logic [4:0] C_T    = 5'b01101;
  localparam logic [4:0] C_R    = 5'b00111;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, out_valid, out_ready, out_err, early_end;
  logic [4:0] in_code;
  logic [2:0] in_dribble;
  logic [3:0] out_data;

  int compared = 0;
  int mismatched = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic       exp_early = 1'b0;
  logic       mark_early = 1'b0;
  logic       acc = 1'b0;
  logic       force_ready = 1'b0;
  logic       stall_prev = 1'b0;
  logic [4:0] stall_word = '0;

  always #5 clk = ~clk;

  pcs_rx_deframer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_dribble(in_dribble), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_err(out_err),
    .early_end(early_end)
  );

  function automatic logic [4:0] enc(logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    #1;
    check("R8 early_end", int'(early_end), int'(exp_early));
    exp_early = 1'b0;
    check("R9 in_ready", int'(in_ready), int'(!out_valid || out_ready));
    if (stall_prev) begin
      check("R9 stalled valid", int'(out_valid), 1);
      check("R9 stalled word", int'({out_err, out_data}), int'(stall_word));
    end
    stall_prev = out_valid && !out_ready;
    stall_word = {out_err, out_data};
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected beat", int'({1'b1, out_err, out_data}), 0);
      end else begin
        automatic logic [4:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'({out_err, out_data}), int'(e));
      end
    end
    acc = in_valid && in_ready;
    if (acc && mark_early) exp_early = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(logic [4:0] code, logic [2:0] drib, logic early);
    in_valid = 1'b1; in_code = code; in_dribble = drib; mark_early = early;
    do begin
      out_ready = force_ready || (($urandom % 4) != 0);
      step();
    end while (!acc);
    in_valid = 1'b0; mark_early = 1'b0;
    if (!force_ready && ($urandom % 6) == 0) begin
      out_ready = ($urandom % 2) != 0;
      step();
    end
  endtask

  function automatic logic [2:0] rdrib();
    return 3'($urandom % 8);
  endfunction

  task automatic frame(int n, logic [2:0] drib, logic by_idle, logic false_car);
    logic [4:0] cq[$];
    logic [4:0] fq[$];
    string      ft[$];
    string      ftag;
    ftag = by_idle ? "R8" : ((drib >= 3'd5) ? "R6" : "R5");
    fq.push_back(5'h05); ft.push_back({"R3 preamble/", ftag});
    fq.push_back(5'h05); ft.push_back({"R3 preamble/", ftag});
    for (int i = 0; i < n; i++) begin
      if (($urandom % 8) == 0) begin
        case ($urandom % 5)
          0: cq.push_back(5'b00000);
          1: cq.push_back(C_J);
          2: cq.push_back(C_K);
          3: cq.push_back(C_R);
          default: cq.push_back(5'b00001);
        endcase
        fq.push_back(5'h10); ft.push_back({"R7 error nibble/", ftag});
      end else begin
        automatic logic [3:0] d = 4'($urandom % 16);
        cq.push_back(enc(d));
        fq.push_back({1'b0, d}); ft.push_back({"R2 data/", ftag});
      end
    end
    if (drib >= 3'd5) begin
      void'(fq.pop_back()); void'(ft.pop_back());
    end
    foreach (fq[i]) begin exp_q.push_back(fq[i]); tag_q.push_back(ft[i]); end
    repeat (1 + $urandom % 3) send(C_IDLE, rdrib(), 1'b0);
    if (false_car) begin
      send(C_J, rdrib(), 1'b0);
      send(enc(4'($urandom % 16)), rdrib(), 1'b0);
      send(C_J, rdrib(), 1'b0);
      send(C_K, rdrib(), 1'b0);
      send(enc(4'h3), rdrib(), 1'b0);
      send(C_IDLE, rdrib(), 1'b0);
    end
    send(C_J, rdrib(), 1'b0);
    send(C_K, rdrib(), 1'b0);
    foreach (cq[i]) send(cq[i], rdrib(), 1'b0);
    if (by_idle) begin
      send(C_IDLE, drib, 1'b1);
    end else begin
      send(C_T, drib, 1'b0);
      send(C_R, rdrib(), 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1; in_valid = 1'b0; in_code = C_IDLE; in_dribble = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset early_end", int'(early_end), 0);
    check("R1 reset in_ready", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset out_valid", int'(out_valid), 0);

    // R10 directed timing with a always-ready sink
    force_ready = 1'b1;
    exp_q.push_back(5'h05); tag_q.push_back("R3 preamble");
    exp_q.push_back(5'h05); tag_q.push_back("R3 preamble");
    exp_q.push_back(5'h0A); tag_q.push_back("R2 data A");
    send(C_IDLE, 3'd0, 1'b0);
    send(C_J, 3'd0, 1'b0);
    send(C_K, 3'd0, 1'b0);
    check("R10 first preamble after K", int'({out_valid, out_data}), int'(5'h15));
    send(enc(4'hA), 3'd0, 1'b0);
    check("R10 second preamble after data", int'({out_valid, out_data}), int'(5'h15));
    send(C_T, 3'd0, 1'b0);
    check("R10 last nibble after T", int'({out_valid, out_err, out_data}), int'(6'h2A));
    send(C_R, 3'd0, 1'b0);
    // R4 J/K straight after T/R without IDLE is ignored
    send(C_J, 3'd0, 1'b0);
    send(C_K, 3'd0, 1'b0);
    send(enc(4'h7), 3'd0, 1'b0);
    send(C_T, 3'd0, 1'b0);
    check("R4 no beat after ignored J/K", int'(out_valid), 0);
    // R6 empty frame with drop: only one preamble
    exp_q.push_back(5'h05); tag_q.push_back("R6 empty frame preamble");
    send(C_IDLE, 3'd0, 1'b0);
    send(C_J, 3'd0, 1'b0);
    send(C_K, 3'd0, 1'b0);
    send(C_T, 3'd6, 1'b0);
    send(C_R, 3'd0, 1'b0);
    send(C_IDLE, 3'd0, 1'b0);
    check("R6 dropped tail absent", int'(out_valid), 0);
    // R8 directed premature end with dribble 7
    frame(3, 3'd7, 1'b1, 1'b0);
    frame(2, 3'd4, 1'b0, 1'b1);
    force_ready = 1'b0;

    for (int f = 0; f < 80; f++) begin
      frame(int'($urandom % 13), rdrib(), ($urandom % 4) == 0, ($urandom % 8) == 0);
    end

    force_ready = 1'b1;
    repeat (4) send(C_IDLE, 3'd0, 1'b0);
    check("R5 all expected beats delivered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule